// File: doc/BRIEF.md
# Bimodal Branch Predictor with Shared Hysteresis

This block is the base direction table of a branch predictor. Every table entry has its own direction bit. One confidence (hysteresis) bit is shared by a group of 2^R neighbouring entries. The direction bit and its group's confidence bit together form a two-bit saturating counter.

A fetch stage presents an index on the lookup port. In the same cycle the block returns the stored direction bit at that index: 1 means taken, 0 means not taken.

When a branch resolves, the back end presents its index and outcome on the update port. The block then does four things:
- it joins the entry's direction bit and the group's confidence bit into the counter value {direction, confidence};
- it steps that value toward the outcome;
- it writes the high bit of the result back to the entry's direction bit;
- it writes the low bit back to the shared confidence bit.

Because the confidence bit is shared, training one branch changes how quickly its neighbours in the same group will flip. Index hashing is done outside the block.

Top module: `bpsh_top`

## Requirements
- R1: After reset, every direction bit is 0, so a lookup at any index returns 0 (not taken). Every confidence bit is 1, so each entry's counter value is 1.
- R2: While `rst` is high, `lkp_taken` is 0 whatever the lookup index.
- R3: `lkp_taken` equals the stored direction bit at `lkp_idx`, combinationally in the same cycle.
- R4: On an update with `upd_taken`=1, the counter value {direction, confidence} is incremented, saturating at 3. The new direction bit is the counter's bit 1, and a later lookup sees it.
- R5: On an update with `upd_taken`=0, the counter value is decremented, saturating at 0. The direction bit is written as in R4.
- R6: The confidence bit of entry i is shared by all entries with the same value of i >> RATIO_LOG. An update writes that shared bit and changes no other confidence bit and no other entry's direction bit.
- R7: If a lookup and an update address the same entry in one cycle, the lookup returns the value from before the update.
- R8: When `upd_valid` is 0, the table is unchanged whatever the other update inputs hold.
- R9: An update presented while `rst` is high is ignored. The reset values are what remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lkp_idx | input | INDEX_LOG | Lookup table index |
| lkp_taken | output | 1 | Predicted direction at `lkp_idx` (1 = taken) |
| upd_valid | input | 1 | Apply an update at the next rising edge |
| upd_idx | input | INDEX_LOG | Index of the resolved branch |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
The lookup result is due in the same cycle as its index. The monitor therefore samples `lkp_taken` one nanosecond after the falling edge on which the driver set the inputs, which is before the rising edge that commits any update in that cycle. An update's effect becomes visible to a lookup from the next cycle onward. The driver advances the reference tables only after that rising edge, so each queued expectation reflects exactly the updates committed before its own cycle. Shared-confidence effects are made visible at the lookup port by training one entry and then checking that a single taken update on a group neighbour does not flip the neighbour's direction.

// File: rtl/bpsh_pkg.sv
package bpsh_pkg;

    // Two-bit counter as held across the two arrays
    typedef struct packed {
        logic dir;   // high bit: predicted direction
        logic conf;  // low bit: shared hysteresis
    } bpsh_ctr_t;

    localparam logic DIR_RESET  = 1'b0;
    localparam logic CONF_RESET = 1'b1;

    function automatic bpsh_ctr_t bpsh_step(input bpsh_ctr_t cur, input logic taken);
        logic [1:0] v;
        bpsh_ctr_t  nxt;
        v = {cur.dir, cur.conf};
        if (taken) begin
            if (v != 2'd3) v = v + 2'd1;
        end else begin
            if (v != 2'd0) v = v - 2'd1;
        end
        nxt.dir  = v[1];
        nxt.conf = v[0];
        return nxt;
    endfunction

endpackage

// File: rtl/bpsh_bit_array.sv
module bpsh_bit_array #(
    parameter int  ADDR_W = 4,
    parameter logic INIT  = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     waddr,
    input  logic                  wdata,
    output logic [(1<<ADDR_W)-1:0] bits
);
    localparam int DEPTH = 1 << ADDR_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits <= {DEPTH{INIT}};
        end else if (we) begin
            bits[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/bpsh_ctr_step.sv
module bpsh_ctr_step
    import bpsh_pkg::*;
(
    input  logic      dir_in,
    input  logic      conf_in,
    input  logic      taken,
    output bpsh_ctr_t next
);
    bpsh_ctr_t cur;

    always_comb begin
        cur.dir  = dir_in;
        cur.conf = conf_in;
        next     = bpsh_step(cur, taken);
    end
endmodule

// File: rtl/bpsh_read_mux.sv
module bpsh_read_mux #(
    parameter int INDEX_LOG = 4
) (
    input  logic                     rst,
    input  logic [(1<<INDEX_LOG)-1:0] dir_bits,
    input  logic [INDEX_LOG-1:0]     idx,
    output logic                     taken
);
    always_comb begin
        taken = rst ? 1'b0 : dir_bits[idx];
    end
endmodule

// File: rtl/bpsh_top.sv
module bpsh_top
    import bpsh_pkg::*;
#(
    parameter int INDEX_LOG = 10,
    parameter int RATIO_LOG = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [INDEX_LOG-1:0] lkp_idx,
    output logic                 lkp_taken,
    input  logic                 upd_valid,
    input  logic [INDEX_LOG-1:0] upd_idx,
    input  logic                 upd_taken
);
    localparam int ENTRIES  = 1 << INDEX_LOG;
    localparam int CONF_LOG = INDEX_LOG - RATIO_LOG;
    localparam int CONF_AW  = (CONF_LOG > 0) ? CONF_LOG : 1;
    localparam int CONF_N   = 1 << CONF_AW;

    generate
        if (RATIO_LOG < 0 || RATIO_LOG > INDEX_LOG) begin : g_bad_params
            $error("bpsh_top: RATIO_LOG must lie in 0..INDEX_LOG");
        end
    endgenerate

    logic [ENTRIES-1:0] dir_bits;
    logic [CONF_N-1:0]  conf_bits;
    logic [CONF_AW-1:0] conf_idx;
    bpsh_ctr_t          next_ctr;
    logic               wr_en;

    // Group index: entry index shifted right by RATIO_LOG
    generate
        if (CONF_LOG > 0) begin : g_grp_idx
            assign conf_idx = upd_idx[INDEX_LOG-1:RATIO_LOG];
        end else begin : g_one_grp
            assign conf_idx = '0;
        end
    endgenerate

    assign wr_en = upd_valid && !rst;

    bpsh_ctr_step u_step (
        .dir_in  (dir_bits[upd_idx]),
        .conf_in (conf_bits[conf_idx]),
        .taken   (upd_taken),
        .next    (next_ctr)
    );

    bpsh_bit_array #(.ADDR_W(INDEX_LOG), .INIT(DIR_RESET)) u_dir (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (upd_idx),
        .wdata (next_ctr.dir),
        .bits  (dir_bits)
    );

    bpsh_bit_array #(.ADDR_W(CONF_AW), .INIT(CONF_RESET)) u_conf (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (conf_idx),
        .wdata (next_ctr.conf),
        .bits  (conf_bits)
    );

    bpsh_read_mux #(.INDEX_LOG(INDEX_LOG)) u_rd (
        .rst      (rst),
        .dir_bits (dir_bits),
        .idx      (lkp_idx),
        .taken    (lkp_taken)
    );
endmodule

// File: rtl/bpsh_checker.sv
module bpsh_checker #(
    parameter int INDEX_LOG = 10,
    parameter int CONF_N    = 256,
    parameter int RATIO_LOG = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     lkp_taken,
    input logic                     upd_valid,
    input logic [INDEX_LOG-1:0]     upd_idx,
    input logic                     upd_taken,
    input logic [(1<<INDEX_LOG)-1:0] dir_bits,
    input logic [CONF_N-1:0]        conf_bits
);
    // R2: no taken prediction while in reset
    always @(posedge clk) begin
        if (rst) begin
            assert_quiet_in_reset_R2: assert (!lkp_taken);
        end
    end

    // R8: idle cycles leave both arrays untouched
    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> ($stable(dir_bits) && $stable(conf_bits)));

    // R4: a taken outcome never clears a set direction bit
    assert_taken_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && dir_bits[upd_idx]) |=> dir_bits[$past(upd_idx)]);

    // R4: counter at 1 or 3 becomes at least 2 when taken
    assert_taken_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && conf_bits[upd_idx >> RATIO_LOG]) |=> dir_bits[$past(upd_idx)]);

    // R5: a not-taken outcome never sets a clear direction bit
    assert_not_taken_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && !dir_bits[upd_idx]) |=> !dir_bits[$past(upd_idx)]);

    // R6: one update touches at most one direction bit and one shared bit
    assert_single_dir_R6: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> ($countones(dir_bits ^ $past(dir_bits)) <= 1));

    assert_single_conf_R6: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> ($countones(conf_bits ^ $past(conf_bits)) <= 1));
endmodule

bind bpsh_top bpsh_checker #(
    .INDEX_LOG (INDEX_LOG),
    .CONF_N    (CONF_N),
    .RATIO_LOG (RATIO_LOG)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lkp_taken (lkp_taken),
    .upd_valid (upd_valid),
    .upd_idx   (upd_idx),
    .upd_taken (upd_taken),
    .dir_bits  (dir_bits),
    .conf_bits (conf_bits)
);

// File: tb/sim_bpsh_top.sv
`timescale 1ns/100ps
module sim_bpsh_top;
    localparam int L = 4;
    localparam int R = 2;
    localparam int N = 1 << L;
    localparam int G = 1 << (L - R);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [L-1:0] lkp_idx = '0;
    logic         lkp_taken;
    logic         upd_valid = 1'b0;
    logic [L-1:0] upd_idx = '0;
    logic         upd_taken = 1'b0;

    always #2.5 clk = ~clk;

    bpsh_top #(.INDEX_LOG(L), .RATIO_LOG(R)) u0 (
        .clk(clk), .rst(rst), .lkp_idx(lkp_idx), .lkp_taken(lkp_taken),
        .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken)
    );

    // Reference tables built from the requirements
    bit    pm [N];
    bit    hm [G];
    bit    exp_q[$];
    string tag_q[$];
    int    errors = 0;
    int    checks = 0;
    bit    done   = 0;

    task automatic model_reset();
        for (int i = 0; i < N; i++) pm[i] = 1'b0;
        for (int g = 0; g < G; g++) hm[g] = 1'b1;
    endtask

    // Driver: one cycle of stimulus, one queued lookup expectation
    task automatic step(input bit r, input bit v, input int ui, input bit ut,
                        input int li, input string tag);
        int c;
        @(negedge clk);
        rst = r; upd_valid = v; upd_idx = ui[L-1:0]; upd_taken = ut; lkp_idx = li[L-1:0];
        exp_q.push_back(r ? 1'b0 : pm[li]);
        tag_q.push_back(tag);
        @(posedge clk);
        if (r) begin
            model_reset();
        end else if (v) begin
            c = pm[ui] * 2 + hm[ui >> R];
            if (ut) begin if (c < 3) c++; end
            else    begin if (c > 0) c--; end
            pm[ui]      = c[1];
            hm[ui >> R] = c[0];
        end
    endtask

    // Monitor: compare each result in the cycle it is due
    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (lkp_taken !== e) begin
                errors++;
                $display("FAIL %s: lkp_taken=%0b expected %0b", t, lkp_taken, e);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R2: lookups during reset are not taken; R9: update in reset ignored
        for (int i = 0; i < 4; i++) step(1, 1, 5, 1, i * 3, "R2");
        step(1, 1, 5, 1, 5, "R9");
        step(0, 0, 0, 0, 5, "R9");
        // R1: all entries not taken after reset
        for (int i = 0; i < N; i++) step(0, 0, 0, 0, i, "R1");
        // R7: same-cycle lookup sees old value; R4: trained taken visible later
        step(0, 1, 0, 1, 0, "R7");
        step(0, 0, 0, 0, 0, "R4");
        // R6: neighbour idx1 now has counter 0, one taken leaves it not taken
        step(0, 1, 1, 1, 1, "R6");
        step(0, 0, 0, 0, 1, "R6");
        step(0, 1, 1, 1, 1, "R6");
        step(0, 0, 0, 0, 1, "R6");
        // R6: other groups untouched
        step(0, 0, 0, 0, 4, "R6");
        // R8: idle update inputs have no effect
        step(0, 0, 8, 1, 8, "R8");
        step(0, 0, 8, 1, 8, "R8");
        step(0, 0, 8, 1, 8, "R8");
        // R5: decrement saturates at 0, then climbs back
        step(0, 1, 4, 0, 4, "R5");
        step(0, 1, 4, 0, 4, "R5");
        step(0, 1, 4, 1, 4, "R5");
        step(0, 0, 0, 0, 4, "R5");
        step(0, 1, 4, 1, 4, "R5");
        step(0, 0, 0, 0, 4, "R5");
        // R4: saturation at 3
        for (int i = 0; i < 3; i++) step(0, 1, 12, 1, 12, "R4");
        step(0, 1, 12, 0, 12, "R4");
        step(0, 0, 0, 0, 12, "R4");
        step(0, 1, 12, 0, 12, "R4");
        step(0, 0, 0, 0, 12, "R4");
        // R3: mixed traffic
        for (int i = 0; i < 600; i++) begin
            int ui, li;
            ui = $urandom_range(0, N - 1);
            li = ($urandom_range(0, 3) == 0) ? ui : $urandom_range(0, N - 1);
            step(0, $urandom_range(0, 3) != 0, ui, $urandom_range(0, 1), li, "R3");
        end
        // R1: reset again restores defaults
        step(1, 0, 0, 0, 0, "R2");
        for (int i = 0; i < N; i++) step(0, 0, 0, 0, i, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule